// File: doc/BRIEF.md
# Counting Parallel Merger

This unit merges two ordered groups of `M` words each into one ordered group of `2M` words in a single clock. It is one stage of a multi-channel merge sorter. A sorter for `N` words chains log2(N/M) of these stages.

Group A arrives in descending order. Group B is also descending, but it arrives rotated cyclically, and a `b_rot` input gives the amount of that rotation. A row of multiplexers first puts group B back in order. The merge then works by counting, with no comparator network:

1. Every A word is compared with every B word.
2. Each word's output position (its rank) is the sum of its own index and the number of words in the other group that must come before it.
3. The rank is decoded into a one-hot select.
4. An AND-OR switch places the word at that position.

Every output word carries a tag that names the input it came from. The merged result, its tags and a valid flag are registered. They appear one clock after the inputs.

Top module: `sgm_merge`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `out_tag` are all zero.
- R2: `out_valid` after each rising edge equals the `in_valid` sampled at that edge. The result of an accepted input group therefore appears one cycle later.
- R3: When inputs are accepted, `out_data` holds all `2M` input words in non-increasing unsigned order. Position 0 holds the largest word. Position `r` occupies bits `[r*W +: W]`, and lane `k` of `grp_a` and of `grp_b` occupies bits `[k*W +: W]`.
- R4: Tag `r` occupies bits `[r*TW +: TW]`, where TW = log2(2M). It names the source of output word `r`. The value `i` in 0..M-1 means lane `i` of `grp_a`. The value `M+j` means element `j` of group B after its order has been restored.
- R5: Restored B element `j` is taken from `grp_b` lane `(j + M - b_rot) mod M`. A `b_rot` of zero therefore passes group B through unchanged.
- R6: Equal words are ordered A before B. Within one group they follow ascending index. So among equal adjacent outputs, the tags strictly increase.
- R7: When `in_valid` is low, `out_data` and `out_tag` keep their previous values, whatever is on the data inputs.
- R8: Words compare as unsigned numbers. A word with its top bit set ranks above every word with that bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the current input groups |
| grp_a | input | M*W | Group A, descending, lane 0 largest |
| grp_b | input | M*W | Group B, descending and rotated by `b_rot` |
| b_rot | input | log2(M) | Rotation amount of group B |
| out_valid | output | 1 | Merged result is present |
| out_data | output | 2M*W | Merged words, position 0 largest |
| out_tag | output | 2M*log2(2M) | Source index of each merged word |

## Verification
Within one clock, restoring group B's order and breaking ties between the groups act on the same words. A wrong rotation shifts which B element counts as equal, or as larger, than a given A element. To provoke this, the bench drives groups that share values, for every rotation amount and in both dominance directions. The merged words and their tags are then compared position by position against a behavioural sort that orders by value and then by source index. A mistake in either function shows up as a wrong tag even when the values happen to line up.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
    // Bit count able to index n items; at least one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sgm_unrotate.sv
// Shift node: undoes the cyclic left rotation of group B (R5).
module sgm_unrotate #(
    parameter int unsigned M  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned RW = 2
) (
    input  logic [M*W-1:0] b_in,
    input  logic [RW-1:0]  rot,
    output logic [M*W-1:0] b_out
);
    always_comb begin
        b_out = '0;
        for (int j = 0; j < M; j++) begin
            logic [RW-1:0] src;
            src = RW'(j) - rot;  // wraps modulo M, M a power of two
            for (int k = 0; k < M; k++) begin
                if (RW'(k) == src) begin
                    b_out[j*W +: W] = b_in[k*W +: W];
                end
            end
        end
    end
endmodule

// File: rtl/sgm_rank.sv
// Pairwise compare and count: output rank of every element.
module sgm_rank #(
    parameter int unsigned M  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned TW = 3
) (
    input  logic [M*W-1:0]  a,
    input  logic [M*W-1:0]  b,
    output logic [M*TW-1:0] rank_a,
    output logic [M*TW-1:0] rank_b
);
    // b_gt[i][j] is set when B[j] > A[i]; its complement is A[i] >= B[j] (R6, R8).
    logic [M-1:0][M-1:0] b_gt;

    always_comb begin
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
                b_gt[i][j] = b[j*W +: W] > a[i*W +: W];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < M; i++) begin
            logic [TW-1:0] acc;
            acc = TW'(i);
            for (int j = 0; j < M; j++) begin
                acc = acc + {{(TW-1){1'b0}}, b_gt[i][j]};
            end
            rank_a[i*TW +: TW] = acc;
        end
        for (int j = 0; j < M; j++) begin
            logic [TW-1:0] acc;
            acc = TW'(j);
            for (int i = 0; i < M; i++) begin
                acc = acc + {{(TW-1){1'b0}}, ~b_gt[i][j]};
            end
            rank_b[j*TW +: TW] = acc;
        end
    end
endmodule

// File: rtl/sgm_place.sv
// Decode ranks to one-hot selects and switch each word into place (R3, R4).
module sgm_place #(
    parameter int unsigned M  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned TW = 3
) (
    input  logic [M*W-1:0]    a,
    input  logic [M*W-1:0]    b,
    input  logic [M*TW-1:0]   rank_a,
    input  logic [M*TW-1:0]   rank_b,
    output logic [2*M*W-1:0]  data,
    output logic [2*M*TW-1:0] tag
);
    localparam int unsigned P = 2 * M;

    logic [M-1:0][P-1:0] sel_a;
    logic [M-1:0][P-1:0] sel_b;

    always_comb begin
        for (int i = 0; i < M; i++) begin
            sel_a[i] = '0;
            sel_a[i][rank_a[i*TW +: TW]] = 1'b1;
            sel_b[i] = '0;
            sel_b[i][rank_b[i*TW +: TW]] = 1'b1;
        end
    end

    always_comb begin
        data = '0;
        tag  = '0;
        for (int r = 0; r < P; r++) begin
            for (int i = 0; i < M; i++) begin
                if (sel_a[i][r]) begin
                    data[r*W +: W]   = data[r*W +: W] | a[i*W +: W];
                    tag[r*TW +: TW]  = tag[r*TW +: TW] | TW'(i);
                end
                if (sel_b[i][r]) begin
                    data[r*W +: W]   = data[r*W +: W] | b[i*W +: W];
                    tag[r*TW +: TW]  = tag[r*TW +: TW] | TW'(M + i);
                end
            end
        end
    end
endmodule

// File: rtl/sgm_merge.sv
// Single-cycle counting merger: unrotate, rank, place, register.
module sgm_merge #(
    parameter int unsigned M = 4,
    parameter int unsigned W = 8,
    parameter int unsigned RW = sgm_pkg::idx_bits(M),
    parameter int unsigned TW = sgm_pkg::idx_bits(2 * M)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [M*W-1:0]       grp_a,
    input  logic [M*W-1:0]       grp_b,
    input  logic [RW-1:0]        b_rot,
    output logic                 out_valid,
    output logic [2*M*W-1:0]     out_data,
    output logic [2*M*TW-1:0]    out_tag
);
    typedef struct packed {
        logic                vld;
        logic [2*M*W-1:0]    data;
        logic [2*M*TW-1:0]   tag;
    } state_t;

    state_t st_d, st_q;

    logic [M*W-1:0]    b_ord;
    logic [M*TW-1:0]   rank_a, rank_b;
    logic [2*M*W-1:0]  merged_data;
    logic [2*M*TW-1:0] merged_tag;

    sgm_unrotate #(.M(M), .W(W), .RW(RW)) u_unrot (
        .b_in  (grp_b),
        .rot   (b_rot),
        .b_out (b_ord)
    );

    sgm_rank #(.M(M), .W(W), .TW(TW)) u_rank (
        .a      (grp_a),
        .b      (b_ord),
        .rank_a (rank_a),
        .rank_b (rank_b)
    );

    sgm_place #(.M(M), .W(W), .TW(TW)) u_place (
        .a      (grp_a),
        .b      (b_ord),
        .rank_a (rank_a),
        .rank_b (rank_b),
        .data   (merged_data),
        .tag    (merged_tag)
    );

    // R2 valid follows input; R7 result held while idle.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = merged_data;
            st_d.tag  = merged_tag;
        end
    end

    // R1 asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_tag   = st_q.tag;
endmodule

// File: rtl/sgm_merge_chk.sv
module sgm_merge_chk #(
    parameter int unsigned M  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned TW = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                out_valid,
    input logic [2*M*W-1:0]    out_data,
    input logic [2*M*TW-1:0]   out_tag
);
    localparam int unsigned P = 2 * M;

    logic [P-1:0] seen;
    always_comb begin
        seen = '0;
        for (int r = 0; r < P; r++) begin
            seen[out_tag[r*TW +: TW]] = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid && out_data == '0 && out_tag == '0);
        end
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_tag_permutation_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&seen));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_tag)));

    for (genvar r = 0; r < P - 1; r++) begin : g_pair
        assert_descending_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_data[r*W +: W] >= out_data[(r+1)*W +: W]);

        assert_tie_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_data[r*W +: W] == out_data[(r+1)*W +: W])
            |-> out_tag[r*TW +: TW] < out_tag[(r+1)*TW +: TW]);
    end
endmodule

bind sgm_merge sgm_merge_chk #(.M(M), .W(W), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/sgm_merge_test.sv
`timescale 1ns/1ps
module sgm_merge_test;
    localparam int M  = 4;
    localparam int W  = 8;
    localparam int RW = 2;
    localparam int TW = 3;
    localparam int P  = 2 * M;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [M*W-1:0]    grp_a = '0;
    logic [M*W-1:0]    grp_b = '0;
    logic [RW-1:0]     b_rot = '0;
    logic              out_valid;
    logic [P*W-1:0]    out_data;
    logic [P*TW-1:0]   out_tag;

    always #10 clk = ~clk;

    sgm_merge #(.M(M), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .grp_a(grp_a), .grp_b(grp_b), .b_rot(b_rot),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Reference state
    logic            exp_vld = 1'b0;
    logic [P*W-1:0]  exp_data = '0;
    logic [P*TW-1:0] exp_tag = '0;

    int av[M];
    int bs[M];

    task automatic sort_desc(inout int v[M]);
        for (int i = 1; i < M; i++) begin
            int x = v[i];
            int k = i;
            while (k > 0 && v[k-1] < x) begin
                v[k] = v[k-1];
                k--;
            end
            v[k] = x;
        end
    endtask

    task automatic fill(input int lo, input int hi);
        for (int i = 0; i < M; i++) begin
            av[i] = $urandom_range(hi, lo);
            bs[i] = $urandom_range(hi, lo);
        end
        sort_desc(av);
        sort_desc(bs);
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== exp_vld) begin
            errors++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_vld);
        end
        checks++;
        if (out_data !== exp_data) begin
            errors++;
            $display("FAIL %s out_data actual=%h expected=%h", cur_req, out_data, exp_data);
        end
        checks++;
        if (out_tag !== exp_tag) begin
            errors++;
            $display("FAIL R4 (%s) out_tag actual=%h expected=%h", cur_req, out_tag, exp_tag);
        end
    endtask

    // Drive one cycle at the falling edge, predict, then check at the next falling edge.
    task automatic apply(input bit vld, input int rot);
        int val[P];
        int tg[P];
        in_valid = vld;
        b_rot    = RW'(rot);
        for (int k = 0; k < M; k++) begin
            grp_a[k*W +: W] = W'(av[k]);
            grp_b[k*W +: W] = W'(bs[(k + rot) % M]);  // R5: rotated left by rot
        end
        exp_vld = vld;
        if (vld) begin
            for (int i = 0; i < M; i++) begin
                val[i] = av[i];     tg[i] = i;
                val[M+i] = bs[i];   tg[M+i] = M + i;
            end
            for (int i = 1; i < P; i++) begin
                int xv = val[i];
                int xt = tg[i];
                int k = i;
                while (k > 0 && val[k-1] < xv) begin
                    val[k] = val[k-1];
                    tg[k] = tg[k-1];
                    k--;
                end
                val[k] = xv;
                tg[k] = xt;
            end
            for (int r = 0; r < P; r++) begin
                exp_data[r*W +: W]  = W'(val[r]);
                exp_tag[r*TW +: TW] = TW'(tg[r]);
            end
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with inputs active during reset
        fill(0, 255);
        in_valid = 1'b1;
        grp_a = '1;
        grp_b = '1;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;

        // R3 random merges with random rotation
        cur_req = "R3";
        for (int n = 0; n < 40; n++) begin
            fill(0, 255);
            apply(1'b1, $urandom_range(M - 1, 0));
        end

        // R5 each rotation amount, including zero
        cur_req = "R5";
        for (int rep = 0; rep < 4; rep++) begin
            for (int rot = 0; rot < M; rot++) begin
                fill(0, 255);
                apply(1'b1, rot);
            end
        end

        // R6 ties: narrow value range, every rotation
        cur_req = "R6";
        for (int n = 0; n < 24; n++) begin
            fill(5, 7);
            apply(1'b1, n % M);
        end
        for (int i = 0; i < M; i++) begin av[i] = 9; bs[i] = 9; end
        apply(1'b1, 1);
        // A wholly above B, then B wholly above A
        fill(200, 255);
        for (int i = 0; i < M; i++) bs[i] = 10 + (M - i);
        apply(1'b1, 3);
        fill(0, 20);
        for (int i = 0; i < M; i++) bs[i] = 240 + (M - i);
        apply(1'b1, 2);

        // R8 unsigned extremes
        cur_req = "R8";
        av[0] = 255; av[1] = 128; av[2] = 127; av[3] = 0;
        bs[0] = 255; bs[1] = 129; bs[2] = 1;   bs[3] = 0;
        apply(1'b1, 1);

        // R7 idle cycles with changing inputs, R2 valid toggling
        cur_req = "R7";
        for (int n = 0; n < 6; n++) begin
            fill(0, 255);
            apply(1'b0, n % M);
        end
        cur_req = "R2";
        for (int n = 0; n < 16; n++) begin
            fill(0, 255);
            apply(n % 3 != 0, $urandom_range(M - 1, 0));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule